// File: doc/BRIEF.md
# Condition Code Flag Unit

This block keeps the 8-bit condition code register of an integer processor core and derives its five flags from each ALU operation. With every update the core presents the class of the operation, the operand size, both operands and the result it has already produced. The block derives negative, zero, overflow, carry and extend from those values and stores them on the next clock edge. The extend flag is also brought out on a port of its own. The adder uses it as carry-in or borrow-in when a wide integer is processed in 8-, 16- or 32-bit pieces.

For subtraction the result is operand A minus operand B (minus extend for the extended form). Software can also overwrite the whole register with a write port, which wins over any flag update in the same cycle. The three upper bits are reserved: they always read as zero, whatever is written. After reset the five flag bits are undefined, and software must load them before any conditional use.

Top module: `ccu_flag_unit`

## Requirements
- R1: The register reads as {3'b000, X, N, Z, V, C}: X is bit 4, N bit 3, Z bit 2, V bit 1, C bit 0. Bits 7..5 read as zero and ignore written values.
- R2: While reset is high, bits 7..5 read as zero. Bits 4..0 are left undefined until a load.
- R3: After an add, subtract or logical update, N equals the most significant bit of the result at the selected size (size code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits). Result bits above that size are ignored.
- R4: After an add (op 0), subtract (op 1) or logical (op 4) update, Z is 1 exactly when the result at the selected size is zero.
- R5: After an add or subtract of any form, V is 1 exactly when the signed result does not fit in the operand size.
- R6: After an add of any form, C is the carry out of the size's top bit. After a subtract of any form, C is the borrow.
- R7: Every add or subtract (ops 0 to 3) copies the new C into X. A logical update (op 4) leaves X unchanged.
- R8: A logical update (op 4) clears V and C.
- R9: Add-with-extend (op 2) uses X as carry-in and subtract-with-extend (op 3) uses X as borrow-in. For both, Z is cleared on a nonzero result and otherwise keeps its previous value.
- R10: A register write (wr_en) stores wr_data[4:0] on the next clock edge and has priority over an update in the same cycle. Nothing changes before that edge.
- R11: ext_q always equals bit 4 of ccr_q.
- R12: With neither wr_en nor upd_en high, or with upd_en and op code 6 or 7, the register keeps its value.
- R13: A load-class update (op 5) copies res[4:0] into the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Apply a flag update from the current operation |
| op_kind | input | 3 | Operation class: 0 add, 1 sub, 2 add-extend, 3 sub-extend, 4 logical/move, 5 load |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 longword |
| opa | input | 32 | First operand (minuend for subtraction) |
| opb | input | 32 | Second operand (subtrahend for subtraction) |
| res | input | 32 | ALU result for the operation |
| wr_en | input | 1 | Write the whole register |
| wr_data | input | 8 | Value for the register write |
| ccr_q | output | 8 | Register contents |
| ext_q | output | 1 | Extend flag, carry/borrow input for chained arithmetic |

## Verification
The hardest situation to reach is the sticky zero of the extended forms. Z must keep a value set by an earlier operation, and X must carry a borrow or carry from the previous piece. This only happens at the second step of a multiprecision chain, with the right flags already in place. The bench builds 64-bit add and subtract chains from two 32-bit steps, and also preloads Z through the write port. Then an all-zero extended result shows both outcomes: Z stays set, and Z stays clear. Separate steps fill the result bits above the selected size with a fixed pattern, so that any use of those bits shows up in N and Z.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int CCR_W     = 8;
    localparam int FLAG_W    = 5;
    localparam int NUM_SIZES = 3;
    localparam logic [CCR_W-1:0] FLAG_MASK = 8'h1F;

    typedef enum logic [2:0] {
        OPK_ADD   = 3'd0,
        OPK_SUB   = 3'd1,
        OPK_ADDX  = 3'd2,
        OPK_SUBX  = 3'd3,
        OPK_LOGIC = 3'd4,
        OPK_LOAD  = 3'd5
    } opk_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } sz_e;

    // Packed so that x lands on bit 4 and c on bit 0.
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic int size_bits(input int idx);
        return 8 << idx;
    endfunction

    // Size code 3 behaves as the widest size.
    function automatic int size_index(input logic [1:0] sz);
        return (sz == 2'd3) ? NUM_SIZES - 1 : int'(sz);
    endfunction

    function automatic logic msb_at(input logic [1:0] sz, input logic [31:0] vec);
        case (size_index(sz))
            0:       return vec[7];
            1:       return vec[15];
            default: return vec[31];
        endcase
    endfunction

    function automatic logic is_arith(input opk_e k);
        return (k == OPK_ADD) || (k == OPK_SUB) || (k == OPK_ADDX) || (k == OPK_SUBX);
    endfunction

    function automatic logic is_extended(input opk_e k);
        return (k == OPK_ADDX) || (k == OPK_SUBX);
    endfunction

    function automatic logic is_subtract(input opk_e k);
        return (k == OPK_SUB) || (k == OPK_SUBX);
    endfunction

    // Carry/borrow and overflow from the sign bits of the operands and result.
    function automatic logic carry_add(input logic a, input logic b, input logic r);
        return (a & b) | (~r & (a | b));
    endfunction

    function automatic logic borrow_sub(input logic a, input logic b, input logic r);
        return (~a & b) | (r & (~a | b));
    endfunction

    function automatic logic ovf_add(input logic a, input logic b, input logic r);
        return (a == b) && (r != a);
    endfunction

    function automatic logic ovf_sub(input logic a, input logic b, input logic r);
        return (a != b) && (r != a);
    endfunction

endpackage

// File: rtl/ccu_size_pick.sv
module ccu_size_pick
    import ccu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] vec,
    output logic          top_bit,
    output logic          all_zero
);

    logic [NUM_SIZES-1:0] msb_v;
    logic [NUM_SIZES-1:0] zero_v;

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_sz
        localparam int W = size_bits(gi);
        assign msb_v[gi]  = vec[W-1];
        assign zero_v[gi] = ~|vec[W-1:0];
    end

    always_comb begin
        top_bit  = msb_v[size_index(size_sel)];
        all_zero = zero_v[size_index(size_sel)];
    end

endmodule

// File: rtl/ccu_flag_gen.sv
module ccu_flag_gen
    import ccu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    op_kind,
    input  logic [1:0]    op_size,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] res,
    input  flags_t        cur,
    output flags_t        nxt,
    output logic          takes
);

    logic r_msb;
    logic r_zero;
    logic a_msb;
    logic b_msb;
    logic cy;
    opk_e kind;

    ccu_size_pick #(.DW(DW)) i_res_pick (
        .size_sel (op_size),
        .vec      (res),
        .top_bit  (r_msb),
        .all_zero (r_zero)
    );

    always_comb begin
        kind  = opk_e'(op_kind);
        a_msb = msb_at(op_size, opa[31:0]);
        b_msb = msb_at(op_size, opb[31:0]);
        nxt   = cur;
        takes = 1'b1;
        cy    = 1'b0;
        if (is_arith(kind)) begin
            cy    = is_subtract(kind) ? borrow_sub(a_msb, b_msb, r_msb)
                                      : carry_add(a_msb, b_msb, r_msb);
            nxt.c = cy;
            nxt.x = cy;
            nxt.v = is_subtract(kind) ? ovf_sub(a_msb, b_msb, r_msb)
                                      : ovf_add(a_msb, b_msb, r_msb);
            nxt.n = r_msb;
            nxt.z = is_extended(kind) ? (cur.z & r_zero) : r_zero;
        end else if (kind == OPK_LOGIC) begin
            nxt.n = r_msb;
            nxt.z = r_zero;
            nxt.v = 1'b0;
            nxt.c = 1'b0;
        end else if (kind == OPK_LOAD) begin
            nxt = flags_t'(res[FLAG_W-1:0]);
        end else begin
            takes = 1'b0;
        end
    end

endmodule

// File: rtl/ccu_flag_store.sv
module ccu_flag_store
    import ccu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CCR_W-1:0] wr_data,
    input  logic             upd_go,
    input  flags_t           upd_flags,
    output flags_t           flags_q
);

    logic [CCR_W-1:0] wr_masked;

    assign wr_masked = wr_data & FLAG_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= 'x;
        end else if (wr_en) begin
            flags_q <= flags_t'(wr_masked[FLAG_W-1:0]);
        end else if (upd_go) begin
            flags_q <= upd_flags;
        end
    end

endmodule

// File: rtl/ccu_flag_unit.sv
module ccu_flag_unit
    import ccu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd_en,
    input  logic [2:0]    op_kind,
    input  logic [1:0]    op_size,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] res,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    output logic [7:0]    ccr_q,
    output logic          ext_q
);

    flags_t cur_flags;
    flags_t nxt_flags;
    logic   takes;

    ccu_flag_gen #(.DW(DW)) i_gen (
        .op_kind (op_kind),
        .op_size (op_size),
        .opa     (opa),
        .opb     (opb),
        .res     (res),
        .cur     (cur_flags),
        .nxt     (nxt_flags),
        .takes   (takes)
    );

    ccu_flag_store i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .upd_go    (upd_en & takes),
        .upd_flags (nxt_flags),
        .flags_q   (cur_flags)
    );

    assign ccr_q = {3'b000, cur_flags};
    assign ext_q = cur_flags.x;

endmodule

// File: rtl/ccu_flag_unit_chk.sv
module ccu_flag_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          upd_en,
    input logic [2:0]    op_kind,
    input logic [DW-1:0] res,
    input logic          wr_en,
    input logic [7:0]    wr_data,
    input logic [7:0]    ccr_q,
    input logic          ext_q
);

    // Flags become defined once loaded by a write or a load-class update.
    logic seeded;
    always_ff @(posedge clk) begin
        if (rst) seeded <= 1'b0;
        else if (wr_en || (upd_en && op_kind == 3'd5)) seeded <= 1'b1;
    end

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ccr_q[7:5] == 3'b000);

    p_ext_mirror_r11: assert property (@(posedge clk) disable iff (rst)
        ext_q == ccr_q[4]);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ccr_q[4:0] == $past(wr_data[4:0]));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (seeded && !wr_en && (!upd_en || op_kind[2:1] == 2'b11)) |=> $stable(ccr_q));

    p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (seeded && !wr_en && upd_en && op_kind == 3'd4) |=> ccr_q[1:0] == 2'b00);

    p_logic_keeps_x_r7: assert property (@(posedge clk) disable iff (rst)
        (seeded && !wr_en && upd_en && op_kind == 3'd4) |=> ext_q == $past(ext_q));

    p_x_follows_c_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && upd_en && op_kind[2] == 1'b0) |=> ccr_q[4] == ccr_q[0]);

    p_ext_z_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (seeded && !wr_en && upd_en && op_kind[2:1] == 2'b01 && !ccr_q[2]) |=> !ccr_q[2]);

    p_load_op_r13: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && upd_en && op_kind == 3'd5) |=> ccr_q[4:0] == $past(res[4:0]));

endmodule

bind ccu_flag_unit ccu_flag_unit_chk #(.DW(DW)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .op_kind (op_kind),
    .res     (res),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ccr_q   (ccr_q),
    .ext_q   (ext_q)
);

// File: tb/test_ccu_flag_unit.sv
module test_ccu_flag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_en = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] res = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  ccr_q;
    logic        ext_q;

    int total = 0;
    int bad = 0;
    logic [4:0] expf = '0;   // {x,n,z,v,c} as the bench expects them

    always #2 clk = ~clk;

    ccu_flag_unit #(.DW(32)) i_ccu_flag_unit (
        .clk(clk), .rst(rst), .upd_en(upd_en), .op_kind(op_kind), .op_size(op_size),
        .opa(opa), .opb(opb), .res(res), .wr_en(wr_en), .wr_data(wr_data),
        .ccr_q(ccr_q), .ext_q(ext_q)
    );

    task automatic check(input string req, input logic [7:0] exp8);
        total++;
        if (ccr_q !== exp8 || ext_q !== exp8[4]) begin
            bad++;
            $display("FAIL %s: ccr_q=%h ext_q=%b expected ccr_q=%h ext_q=%b",
                     req, ccr_q, ext_q, exp8, exp8[4]);
        end
    endtask

    task automatic write_reg(input logic [7:0] d, input string req);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        expf = d[4:0];
        check(req, {3'b000, expf});
    endtask

    // Applies one arithmetic or logical operation and checks the flags.
    task automatic run_op(input logic [2:0] k, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] b, input string req);
        int     w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        longint m = (longint'(1) << w) - 1;
        longint ua = longint'(a) & m;
        longint ub = longint'(b) & m;
        longint half = longint'(1) << (w - 1);
        longint sa = (ua >= half) ? ua - (longint'(1) << w) : ua;
        longint sb = (ub >= half) ? ub - (longint'(1) << w) : ub;
        longint xi = (k == 3'd2 || k == 3'd3) ? longint'(expf[4]) : 0;
        longint u, s, rl;
        logic c, v, n, z;
        if (k == 3'd4) begin
            rl = ua;
            c = 1'b0; v = 1'b0;
            res = a;
        end else begin
            if (k == 3'd1 || k == 3'd3) begin
                u = ua - ub - xi; s = sa - sb - xi; c = (u < 0);
            end else begin
                u = ua + ub + xi; s = sa + sb + xi; c = (u > m);
            end
            rl = u & m;
            v = (s > half - 1) || (s < -half);
            res = (32'hA5A5_A5A5 & ~m[31:0]) | rl[31:0];
        end
        n = rl[w-1];
        z = (rl == 0);
        if (k == 3'd2 || k == 3'd3) z = z & expf[2];
        if (k == 3'd4) expf = {expf[4], n, z, v, c};
        else           expf = {c, n, z, v, c};
        op_kind = k; op_size = sz; opa = a; opb = b; upd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        upd_en = 1'b0;
        check(req, {3'b000, expf});
    endtask

    task automatic t_reset;
        @(negedge clk);
        total++;
        if (ccr_q[7:5] !== 3'b000) begin
            bad++;
            $display("FAIL R2: upper bits %b expected 000", ccr_q[7:5]);
        end
        rst = 1'b0;
    endtask

    task automatic t_write;
        write_reg(8'hFF, "R1 reserved bits ignore ones");
        write_reg(8'hE0, "R1 only reserved bits set");
        write_reg(8'h0A, "R10 plain write");
    endtask

    task automatic t_add;
        write_reg(8'h00, "R10 clear before add");
        run_op(3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, "R3 R5 byte add overflow");
        run_op(3'd0, 2'd0, 32'h1234_56FF, 32'h0000_0001, "R4 R6 R7 byte add carry zero");
        run_op(3'd0, 2'd1, 32'h0000_8000, 32'h0000_8000, "R5 R6 word add wrap");
        run_op(3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, "R3 R5 long add overflow");
        run_op(3'd0, 2'd3, 32'h0000_0010, 32'h0000_0020, "R3 size code 3 acts as long");
    endtask

    task automatic t_sub;
        run_op(3'd1, 2'd0, 32'h0000_0000, 32'h0000_0001, "R6 R7 byte borrow");
        run_op(3'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, "R5 byte sub overflow");
        run_op(3'd1, 2'd2, 32'h0000_0005, 32'h0000_0005, "R4 long sub zero");
        run_op(3'd1, 2'd1, 32'h0000_7FFF, 32'h0000_FFFF, "R5 word sub overflow");
    endtask

    task automatic t_logic;
        write_reg(8'h13, "R10 set X V C");
        run_op(3'd4, 2'd0, 32'hFFFF_FF00, 32'h0, "R8 R7 logic zero keeps X");
        run_op(3'd4, 2'd1, 32'h0000_8001, 32'h0, "R3 R8 logic negative word");
        write_reg(8'h00, "R10 clear X");
        run_op(3'd4, 2'd2, 32'h0000_0001, 32'h0, "R7 logic keeps X clear");
    endtask

    task automatic t_chain;
        run_op(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R6 low half add carry");
        run_op(3'd2, 2'd2, 32'h0000_0000, 32'h0000_0000, "R9 high half takes X clears Z");
        run_op(3'd0, 2'd2, 32'h0000_0000, 32'h0000_0000, "R4 low half add zero");
        run_op(3'd2, 2'd2, 32'h0000_0000, 32'h0000_0000, "R9 extended zero keeps Z set");
        write_reg(8'h00, "R10 Z clear before extended");
        run_op(3'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, "R9 extended zero keeps Z clear");
        run_op(3'd1, 2'd2, 32'h0000_0000, 32'h0000_0001, "R6 low half sub borrow");
        run_op(3'd3, 2'd2, 32'h0000_0001, 32'h0000_0000, "R9 high half borrow in");
        write_reg(8'h14, "R10 X and Z set");
        run_op(3'd3, 2'd0, 32'h0000_0080, 32'h0000_0000, "R9 R5 byte subx overflow");
    endtask

    task automatic t_prio;
        write_reg(8'h00, "R10 clear");
        wr_en = 1'b1; wr_data = 8'h09;
        op_kind = 3'd0; op_size = 2'd0; opa = 32'hFF; opb = 32'h1; res = 32'h0; upd_en = 1'b1;
        #1;
        check("R10 no change before edge", 8'h00);
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; upd_en = 1'b0;
        expf = 5'h09;
        check("R10 write beats update", 8'h09);
    endtask

    task automatic t_hold;
        write_reg(8'h1B, "R10 preset");
        op_kind = 3'd0; op_size = 2'd0; opa = 32'hFF; opb = 32'h1; res = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R12 idle hold", 8'h1B);
        op_kind = 3'd6; upd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        op_kind = 3'd7;
        @(posedge clk); @(negedge clk);
        upd_en = 1'b0;
        check("R12 unused op codes hold", 8'h1B);
    endtask

    task automatic t_load;
        op_kind = 3'd5; res = 32'hFFFF_FF35; upd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        upd_en = 1'b0;
        expf = 5'h15;
        check("R13 load op copies low bits", 8'h15);
        check("R11 ext mirrors bit 4", {3'b000, expf});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_write();
        t_add();
        t_sub();
        t_logic();
        t_chain();
        t_prio();
        t_hold();
        t_load();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule